// File: doc/BRIEF.md
# Receive Frame Size Check and Statistics

This block sits after a receive MAC's framing logic. For each finished frame it gets a strobe, the frame length with the FCS left out, and a packet type. From the length and two control bits it decides whether to keep or drop the frame, and it reports that decision on a pair of one-cycle outputs. It also keeps a bank of statistics counters.

A frame that is kept updates several counters: one size bin, the total-packet and good-packet counters, the broadcast or multicast counter where the type calls for it, and two double-width octet totals. Each octet total adds the frame length plus four FCS bytes. A frame that is dropped updates only the oversize counter. No counter ever wraps: each one stops at all-ones.

Software reads the counters through a one-cycle-latency read port. Every read clears the counter it returns. A double-width counter is read as a low word and then a high word. Reading the low word clears the whole counter and also captures its upper half, so the high word read next matches the low word already returned.

Top module: `rx_size_stats`

## Requirements
- R1: One clock edge after a cycle with frameDone high, exactly one of frameOk and frameDrop pulses for one cycle. The length limit is 1518 when longPktEn is low and 16380 when it is high. A longer frame gives frameDrop, and any other frame gives frameOk.
- R2: A frame dropped for length adds one to the oversize counter at address 0. When storeBadPkts is high, frames over the limit are kept (frameOk) and the oversize counter is left unchanged.
- R3: Every counter saturates at all-ones and never wraps to zero.
- R4: A kept frame adds one to exactly one size bin, or to none if it is shorter than 64. The bins are: length 64 exactly (address 1), 65 to 127 (address 2), 128 to 255 (address 3), 256 to 511 (address 4), 512 to 1023 (address 5), and over 1023 (address 6).
- R5: A kept frame adds one to the total-packet counter (address 7) and to the good-packet counter (address 8). frameType 2'b10 marks broadcast and adds one at address 9. frameType 2'b01 marks multicast and adds one at address 10. Codes 2'b00 and 2'b11 are unicast and touch neither of those two counters.
- R6: The total-octet counter (low word at address 11, high at 12) and the good-octet counter (low at 13, high at 14) are each two counter words wide. Each adds frameLen+4 for every kept frame and nothing for a dropped frame.
- R7: Reading an octet low word captures the upper half of that counter in the same edge. A later read of the high address returns that captured value, even if the counter has changed since.
- R8: The read port has one cycle of latency. rdData shows the value the addressed counter held at the rdEn edge, and the read clears that counter. Reading an octet low word clears the whole octet counter. Addresses 15 and above read as zero.
- R9: A counter's clear can fall on the same edge as its increment. The read then returns the old value, and the counter restarts from the increment amount, so that count is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameDone | input | 1 | One-cycle strobe: a frame has finished |
| frameLen | input | LEN_W | Frame length in bytes, FCS excluded |
| frameType | input | 2 | 00/11 unicast, 01 multicast, 10 broadcast |
| longPktEn | input | 1 | Raises the length limit to 16380 |
| storeBadPkts | input | 1 | Keeps over-length frames |
| frameOk | output | 1 | Frame kept (one cycle) |
| frameDrop | output | 1 | Frame dropped as oversized (one cycle) |
| rdEn | input | 1 | Read strobe (clears the addressed counter) |
| rdAddr | input | ADDR_W | Counter address |
| rdData | output | CNT_W | Read data, valid the cycle after rdEn |

## Verification
A counter's clear-on-read and its increment can fall on the same clock edge. A frame's strobe lands in the counters one edge after it is registered, so the bench raises rdEn for the total-packet counter, and separately for an octet low word, in exactly that cycle. It judges the result by two values: the read must return the count from before the frame, and the read that follows must return the new frame's contribution and nothing more. Saturation and the high-word capture are reached quickly by building the bench with a narrow counter width.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int NUM_BINS = 6;
  localparam int NUM_PKT  = 11;

  // Register addresses; the low/high pairing of octet counters matters.
  localparam int ADR_OVERSIZE = 0;
  localparam int ADR_BIN0     = 1;
  localparam int ADR_TOTAL    = 7;
  localparam int ADR_GOOD     = 8;
  localparam int ADR_BCAST    = 9;
  localparam int ADR_MCAST    = 10;
  localparam int ADR_OCT_BASE = 11;
  localparam int NUM_OCT      = 2;

  // Inclusive length range of each size bin.
  localparam int BIN_LO [NUM_BINS] = '{64, 65, 128, 256, 512, 1024};
  localparam int BIN_HI [NUM_BINS] = '{64, 127, 255, 511, 1023, 32'h7fff_ffff};

  typedef struct packed {
    logic                oversize;
    logic [NUM_BINS-1:0] bin;
    logic                good;
    logic                bcast;
    logic                mcast;
  } rxsStrb_t;

endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int HDR_BYTES   = 14,
  parameter int TAG_BYTES   = 4,
  parameter int MTU_BYTES   = 1500,
  parameter int JUMBO_BYTES = 16384,
  parameter int FCS_BYTES   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [1:0]       frameType,
  input  logic             longPktEn,
  input  logic             storeBadPkts,
  output rxsStrb_t         strb,
  output logic [LEN_W-1:0] lenOut,
  output logic             frameOk,
  output logic             frameDrop
);

  localparam int SHORT_MAX = HDR_BYTES + TAG_BYTES + MTU_BYTES;
  localparam int LONG_MAX  = JUMBO_BYTES - FCS_BYTES;

  logic [31:0] lenExt;
  logic [31:0] limit;
  logic        isOver;
  logic        keep;
  rxsStrb_t    strbNext;

  always_comb begin
    lenExt = 32'(frameLen);
    limit  = longPktEn ? 32'(LONG_MAX) : 32'(SHORT_MAX);
    isOver = lenExt > limit;
    keep   = !isOver || storeBadPkts;

    strbNext          = '0;
    strbNext.oversize = frameDone && !keep;
    strbNext.good     = frameDone && keep;
    strbNext.bcast    = frameDone && keep && (frameType == 2'b10);
    strbNext.mcast    = frameDone && keep && (frameType == 2'b01);
    for (int b = 0; b < NUM_BINS; b++) begin
      strbNext.bin[b] = frameDone && keep &&
                        (lenExt >= 32'(BIN_LO[b])) && (lenExt <= 32'(BIN_HI[b]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strb      <= '0;
      lenOut    <= '0;
      frameOk   <= 1'b0;
      frameDrop <= 1'b0;
    end else begin
      strb      <= strbNext;
      lenOut    <= frameLen;
      frameOk   <= frameDone && keep;
      frameDrop <= frameDone && !keep;
    end
  end

  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !longPktEn && !storeBadPkts && (32'(frameLen) > 32'(SHORT_MAX)))
      |=> (frameDrop && !frameOk)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> !(frameOk || frameDrop)); // R1

  AST_STOREBAD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && storeBadPkts) |=> (frameOk && !frameDrop)); // R2

endmodule

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxsStrb_t          strb,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData
);

  localparam int OCT_W = 2 * CNT_W;
  localparam int FCS_ADD = 4;

  logic [CNT_W-1:0]   pktCnt  [NUM_PKT];
  logic [NUM_PKT-1:0] pktInc;
  logic [OCT_W-1:0]   octCnt  [NUM_OCT];
  logic [CNT_W-1:0]   hiLatch [NUM_OCT];
  logic [CNT_W-1:0]   rdNext;

  // bit 0 oversize, 1..6 bins, 7 total, 8 good, 9 broadcast, 10 multicast
  assign pktInc = {strb.mcast, strb.bcast, strb.good, strb.good, strb.bin, strb.oversize};

  for (genvar g = 0; g < NUM_PKT; g++) begin : gPkt
    logic             pktClr;
    logic [CNT_W:0]   pktSum;
    assign pktClr = rdEn && (rdAddr == ADDR_W'(g));
    assign pktSum = {1'b0, pktCnt[g]} + 1'b1;

    always_ff @(posedge clk) begin
      if (!rstN)            pktCnt[g] <= '0;
      else if (pktInc[g])   pktCnt[g] <= pktClr ? CNT_W'(1)
                                                : (pktSum[CNT_W] ? '1 : pktSum[CNT_W-1:0]);
      else if (pktClr)      pktCnt[g] <= '0;
    end

    AST_PKT_SAT: assert property (@(posedge clk) disable iff (!rstN)
      ((pktCnt[g] == '1) && !pktClr) |=> (pktCnt[g] == '1)); // R3

    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (pktClr && !pktInc[g]) |=> (pktCnt[g] == '0)); // R8

    AST_RD_PRIO: assert property (@(posedge clk) disable iff (!rstN)
      (pktClr && pktInc[g]) |=> (pktCnt[g] == CNT_W'(1))); // R9
  end

  for (genvar o = 0; o < NUM_OCT; o++) begin : gOct
    logic             octClr;
    logic [OCT_W-1:0] octAdd;
    logic [OCT_W:0]   octSum;
    assign octClr = rdEn && (rdAddr == ADDR_W'(ADR_OCT_BASE + 2 * o));
    assign octAdd = OCT_W'(lenIn) + OCT_W'(FCS_ADD);
    assign octSum = {1'b0, octCnt[o]} + {1'b0, octAdd};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        octCnt[o]  <= '0;
        hiLatch[o] <= '0;
      end else begin
        if (strb.good)    octCnt[o] <= octClr ? octAdd
                                              : (octSum[OCT_W] ? '1 : octSum[OCT_W-1:0]);
        else if (octClr)  octCnt[o] <= '0;
        if (octClr)       hiLatch[o] <= octCnt[o][OCT_W-1:CNT_W];
      end
    end

    AST_OCT_ADD: assert property (@(posedge clk) disable iff (!rstN)
      (strb.good && !octClr && (octCnt[o][OCT_W-1 -: 2] == 2'b00))
        |=> (octCnt[o] == $past(octCnt[o]) + OCT_W'($past(lenIn)) + OCT_W'(FCS_ADD))); // R6

    AST_OCT_SAT: assert property (@(posedge clk) disable iff (!rstN)
      ((octCnt[o] == '1) && !octClr) |=> (octCnt[o] == '1)); // R3
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_PKT; i++) begin
      if (rdAddr == ADDR_W'(i)) rdNext = pktCnt[i];
    end
    for (int j = 0; j < NUM_OCT; j++) begin
      if (rdAddr == ADDR_W'(ADR_OCT_BASE + 2 * j))     rdNext = octCnt[j][CNT_W-1:0];
      if (rdAddr == ADDR_W'(ADR_OCT_BASE + 2 * j + 1)) rdNext = hiLatch[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  AST_BIN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.bin)); // R4

  AST_BIN_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bin != '0) |-> strb.good); // R4

endmodule

// File: rtl/rx_size_stats.sv
module rx_size_stats
  import rxs_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [1:0]        frameType,
  input  logic              longPktEn,
  input  logic              storeBadPkts,
  output logic              frameOk,
  output logic              frameDrop,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData
);

  rxsStrb_t         strb;
  logic [LEN_W-1:0] lenQ;

  rxs_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameLen(frameLen),
    .frameType(frameType), .longPktEn(longPktEn), .storeBadPkts(storeBadPkts),
    .strb(strb), .lenOut(lenQ), .frameOk(frameOk), .frameDrop(frameDrop)
  );

  rxs_datapath #(.CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .lenIn(lenQ),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: tb/sim_rx_size_stats.sv
module sim_rx_size_stats;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              frameDone = 1'b0;
  logic [LEN_W-1:0]  frameLen = '0;
  logic [1:0]        frameType = 2'b00;
  logic              longPktEn = 1'b0;
  logic              storeBadPkts = 1'b0;
  logic              frameOk, frameDrop;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [CNT_W-1:0]  rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rx_size_stats #(.CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u0 (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input longint actual, input longint expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic sendFrame(input int len, input logic [1:0] ty, input bit expKeep);
    @(negedge clk);
    frameDone = 1'b1; frameLen = LEN_W'(len); frameType = ty;
    @(negedge clk);
    frameDone = 1'b0;
    chk("R1 frameOk",   frameOk,   expKeep);
    chk("R1 frameDrop", frameDrop, !expKeep);
    @(negedge clk);
  endtask

  task automatic readReg(input int addr, output longint val);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = ADDR_W'(addr);
    @(negedge clk);
    rdEn = 1'b0;
    val = longint'(rdData);
  endtask

  task automatic expectReg(input string req, input int addr, input longint expected);
    longint v;
    readReg(addr, v);
    chk(req, v, expected);
  endtask

  task automatic clearAll();
    longint v;
    for (int a = 0; a < 15; a++) readReg(a, v);
  endtask

  task automatic testReset();
    for (int a = 0; a < 15; a++) expectReg("R8 reset value", a, 0);
    sendFrame(100, 2'b00, 1'b1);
    expectReg("R8 unmapped addr 15", 15, 0);
    expectReg("R8 unmapped addr 31", 31, 0);
    clearAll();
  endtask

  task automatic testBins();
    int lens [11] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024};
    longint oct = 0;
    foreach (lens[i]) begin
      sendFrame(lens[i], 2'b00, 1'b1);
      oct += lens[i] + 4;
    end
    expectReg("R4 bin 64",        1, 1);
    expectReg("R4 bin 65-127",    2, 2);
    expectReg("R4 bin 128-255",   3, 2);
    expectReg("R4 bin 256-511",   4, 2);
    expectReg("R4 bin 512-1023",  5, 2);
    expectReg("R4 bin over 1023", 6, 1);
    expectReg("R5 total packets", 7, 11);
    expectReg("R5 good packets",  8, 11);
    expectReg("R5 no bcast",      9, 0);
    expectReg("R5 no mcast",     10, 0);
    expectReg("R6 total oct lo", 11, oct & 8'hff);
    expectReg("R6 total oct hi", 12, (oct >> 8) & 8'hff);
    expectReg("R6 good oct lo",  13, oct & 8'hff);
    expectReg("R6 good oct hi",  14, (oct >> 8) & 8'hff);
    expectReg("R8 cleared after read", 7, 0);
    expectReg("R8 cleared after read", 1, 0);
    clearAll();
  endtask

  task automatic testOversize();
    longint oct;
    longPktEn = 1'b0; storeBadPkts = 1'b0;
    sendFrame(1518, 2'b00, 1'b1);
    sendFrame(1519, 2'b00, 1'b0);
    longPktEn = 1'b1;
    sendFrame(16380, 2'b00, 1'b1);
    sendFrame(16381, 2'b10, 1'b0);
    longPktEn = 1'b0; storeBadPkts = 1'b1;
    sendFrame(2000, 2'b00, 1'b1);
    storeBadPkts = 1'b0;
    oct = 1522 + 16384 + 2004;
    expectReg("R2 oversize count",  0, 2);
    expectReg("R1 kept in top bin", 6, 3);
    expectReg("R1 total kept",      7, 3);
    expectReg("R2 dropped bcast not counted", 9, 0);
    expectReg("R6 good oct lo",    13, oct & 8'hff);
    expectReg("R6 good oct hi",    14, (oct >> 8) & 8'hff);
    clearAll();
  endtask

  task automatic testTypes();
    sendFrame(100, 2'b10, 1'b1);
    sendFrame(100, 2'b10, 1'b1);
    sendFrame(100, 2'b01, 1'b1);
    sendFrame(100, 2'b01, 1'b1);
    sendFrame(100, 2'b01, 1'b1);
    sendFrame(100, 2'b00, 1'b1);
    sendFrame(100, 2'b11, 1'b1);
    expectReg("R5 broadcast",  9, 2);
    expectReg("R5 multicast", 10, 3);
    expectReg("R5 total",      7, 7);
    clearAll();
  endtask

  task automatic testLatch();
    for (int i = 0; i < 3; i++) sendFrame(1000, 2'b00, 1'b1);
    expectReg("R7 low word", 13, 3012 & 8'hff);
    sendFrame(100, 2'b00, 1'b1);
    expectReg("R7 captured high", 14, 3012 >> 8);
    expectReg("R7 next low",      13, 104);
    expectReg("R7 next high",     14, 0);
    clearAll();
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 300; i++) sendFrame(64, 2'b00, 1'b1);
    expectReg("R3 bin saturates",   1, 255);
    expectReg("R3 total saturates", 7, 255);
    longPktEn = 1'b1;
    for (int i = 0; i < 5; i++) sendFrame(16000, 2'b00, 1'b1);
    longPktEn = 1'b0;
    expectReg("R3 octet lo saturates", 11, 255);
    expectReg("R3 octet hi saturates", 12, 255);
    clearAll();
  endtask

  task automatic testCollide(input int addr, input longint expOld, input longint expNew);
    @(negedge clk);
    frameDone = 1'b1; frameLen = LEN_W'(300); frameType = 2'b00;
    @(negedge clk);
    frameDone = 1'b0;
    rdEn = 1'b1; rdAddr = ADDR_W'(addr);
    @(negedge clk);
    rdEn = 1'b0;
    chk("R9 read returns old value", longint'(rdData), expOld);
    expectReg("R9 increment kept", addr, expNew);
  endtask

  task automatic testConflict();
    sendFrame(200, 2'b00, 1'b1);
    testCollide(7, 1, 1);
    clearAll();
    sendFrame(200, 2'b00, 1'b1);
    testCollide(11, 204, 304 & 8'hff);
    expectReg("R9 octet high after collide", 12, 304 >> 8);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 frameOk idle after reset", frameOk, 0);
    testReset();
    testBins();
    testOversize();
    testTypes();
    testLatch();
    testSaturate();
    testConflict();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule